// File: doc/BRIEF.md
# Time-Division Line Port with Activation Handshake

This block is the line side of a serial port on a four-wire time-division bus. It carries a 96-bit frame made of three 32-bit sub-frames. An incoming data clock runs at twice the bit rate, so each bit spans two rising edges of that clock. The first rising edge of a bit moves the transmit data. The second rising edge samples the receive data. A rising frame-sync pulse, seen on a data-clock edge, starts a frame at bit 0. The receive and transmit sides share this one clock and sync. Without a new sync, the bit count wraps on its own after the last bit.

Each sub-frame holds eight bits for each of two bearer channels, eight bits of monitor, two D bits, a four-bit command/indicate (C/I) field and two handshake bits. The port deals with three things in the first sub-frame and one other bit:
- It sends a host-supplied C/I code on the line.
- It collects the received C/I code. A new indication counts only when the same code arrives in two frames in a row and differs from the code already held.
- It latches the collision-grant bit at a fixed bit position.

The port also runs line activation. While the line is down, no clock is present and the output is released. The first data-clock edge brings the line up. When that clock has been missing for a set number of system-clock cycles, the line goes back down. The host can hold the output low at any time, which sends an all-zero C/I code (the timing command) until the host lets go. A new indication raises a pending flag. The flag reaches the interrupt pin only while the host enables it.

Top module: `gci_port`

## Requirements
- R1: After reset the line is down (`lineActive`=0), the output is released (`txLow`=0), `irqOut` is 0 and `ciRxCode` is 4'b1111.
- R2: A rising edge on `busClk` while the line is down brings the line up (`lineActive`=1).
- R3: When `busClk` has no rising edge for `LOSS_CYCLES` system-clock cycles (default 64), the line goes down and `txLow` returns to 0 unless `forceZero` is set. A gap of fewer cycles keeps the line up.
- R4: While `forceZero` is 1, `txLow` is 1 in every bit, whether the line is up or down. This makes the C/I field read 4'b0000.
- R5: While the line is up, the port is framed and `forceZero` is 0, bits 26..29 of the frame carry `ciTxCode`, MSB first. Bit 26 carries `ciTxCode[3]`. For each of these bits, `txLow` is 1 exactly when the code bit is 0. All other bits are released (`txLow`=0).
- R6: The code received in bits 26..29 (MSB first, sampled on the second clock edge of each bit) is copied to `ciRxCode` only if the same code arrived in the previous frame and it differs from the current `ciRxCode`. Alternating codes and repeats of the held code change nothing.
- R7: Each update of `ciRxCode` sets a pending flag. `irqClr` clears the flag. `irqOut` is the pending flag gated by `irqEn`, and a masked flag is kept until it is cleared.
- R8: The bit received at position `GRANT_POS` (default 88) is presented on `grantOut`, with a one-cycle `grantStrobe`.
- R9: A rising `busSync` on a data-clock edge restarts the count at bit 0. After bit 95 the count wraps to bit 0 without a new sync, and the fields keep their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Bus data clock, twice the bit rate |
| busSync | input | 1 | Frame sync pulse |
| busRxd | input | 1 | Received line data |
| txLow | output | 1 | Open-drain pull-down: 1 drives the line low, 0 releases it |
| forceZero | input | 1 | Host hold of the output at zero |
| ciTxCode | input | 4 | C/I code to send |
| irqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Clears the pending indication |
| lineActive | output | 1 | Line up |
| ciRxCode | output | 4 | Last accepted indication |
| irqOut | output | 1 | Indication interrupt |
| grantOut | output | 1 | Last sampled collision-grant bit |
| grantStrobe | output | 1 | One-cycle pulse when the grant bit is sampled |

## Verification
The indication filter gets four receive patterns:
- a single frame with a new code, which must not latch;
- the same new code in two frames, which must latch;
- a repeat of the held code, which must not raise an interrupt;
- alternating codes, which must never latch.

These tell a correct two-frame check apart from one that compares against the wrong reference. A frame that follows with no sync confirms the wrap of the bit count. The transmit side is checked bit by bit, using a code whose bits are not all equal, and once more under the hold to zero. A grant bit of 0, then 1, checks the sampling position. Clock gaps just under and well over the loss limit check deactivation.

// File: rtl/gci_port_pkg.sv
package gci_port_pkg;
  localparam int SUB_BITS = 32;
  localparam int CI_OFS   = 26;
  localparam int CI_W     = 4;

  typedef struct packed {
    logic lineUp;
    logic forceLow;
    logic dropSync;
  } ctlStrobe_t;

  typedef enum logic {
    LINE_DOWN = 1'b0,
    LINE_UP   = 1'b1
  } lineState_t;
endpackage

// File: rtl/gci_port_dp.sv
module gci_port_dp
  import gci_port_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  parameter int GRANT_POS  = 88
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busClk,
  input  logic            busSync,
  input  logic            busRxd,
  input  logic [CI_W-1:0] ciTxCode,
  input  ctlStrobe_t      ctl,
  output logic            dclEdge,
  output logic            ciDone,
  output logic [CI_W-1:0] ciCode,
  output logic            txLow,
  output logic            grantOut,
  output logic            grantStrobe
);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] CI_FIRST = POS_W'(CI_OFS);
  localparam logic [POS_W-1:0] CI_LAST  = POS_W'(CI_OFS + CI_W - 1);
  localparam logic [POS_W-1:0] GRANT_P  = POS_W'(GRANT_POS);

  logic             clkQ;
  logic             syncPrev;
  logic             phaseB;
  logic             synced;
  logic [POS_W-1:0] bitPos;
  logic [CI_W-2:0]  ciShift;
  logic             frameStart;
  logic             edgeA;
  logic             edgeB;
  logic             txBit;

  // Edge detection on the bus clock; bit halves alternate between edges.
  assign dclEdge    = busClk & ~clkQ;
  assign frameStart = dclEdge & busSync & ~syncPrev;
  assign edgeA      = dclEdge & (frameStart | ~phaseB);
  assign edgeB      = dclEdge & ~frameStart & phaseB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ     <= 1'b0;
      syncPrev <= 1'b0;
      phaseB   <= 1'b0;
      synced   <= 1'b0;
      bitPos   <= LAST_POS;
    end else begin
      clkQ <= busClk;
      if (dclEdge) syncPrev <= busSync;
      if (edgeA) begin
        phaseB <= 1'b1;
        if (frameStart || bitPos == LAST_POS) bitPos <= '0;
        else bitPos <= bitPos + 1'b1;
      end else if (edgeB) begin
        phaseB <= 1'b0;
      end
      if (ctl.dropSync) synced <= 1'b0;
      else if (frameStart) synced <= 1'b1;
    end
  end

  // Receive: C/I collection and grant sampling on the second edge of a bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ciShift     <= '1;
      ciCode      <= '1;
      ciDone      <= 1'b0;
      grantOut    <= 1'b1;
      grantStrobe <= 1'b0;
    end else begin
      ciDone      <= 1'b0;
      grantStrobe <= 1'b0;
      if (edgeB && synced) begin
        if (bitPos >= CI_FIRST && bitPos < CI_LAST)
          ciShift <= {ciShift[CI_W-3:0], busRxd};
        if (bitPos == CI_LAST) begin
          ciCode <= {ciShift, busRxd};
          ciDone <= 1'b1;
        end
        if (bitPos == GRANT_P) begin
          grantOut    <= busRxd;
          grantStrobe <= 1'b1;
        end
      end
    end
  end

  // Transmit: C/I field MSB first, every other bit released.
  always_comb begin
    txBit = 1'b1;
    for (int k = 0; k < CI_W; k++) begin
      if (synced && bitPos == POS_W'(CI_OFS + k)) txBit = ciTxCode[CI_W-1-k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txLow <= 1'b0;
    else txLow <= ctl.forceLow | (ctl.lineUp & ~txBit);
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= LAST_POS); // R9
  AST_GRANT_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != $past(grantOut)) |-> grantStrobe); // R8
  AST_FORCE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceLow |=> txLow); // R4
  AST_RELEASE_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.lineUp && !ctl.forceLow) |=> !txLow); // R3
  AST_CI_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ciDone |=> !ciDone); // R6
endmodule

// File: rtl/gci_port_ctl.sv
module gci_port_ctl
  import gci_port_pkg::*;
#(
  parameter int LOSS_CYCLES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dclEdge,
  input  logic            ciDone,
  input  logic [CI_W-1:0] ciCode,
  input  logic            forceZero,
  input  logic            irqEn,
  input  logic            irqClr,
  output ctlStrobe_t      ctl,
  output logic            lineActive,
  output logic [CI_W-1:0] ciRxCode,
  output logic            irqOut
);
  localparam int LOSS_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_CYCLES - 1);

  lineState_t      state;
  logic [LOSS_W-1:0] lossCnt;
  logic [CI_W-1:0] prevCode;
  logic            prevValid;
  logic            irqPend;
  logic            lossHit;
  logic            newInd;

  assign lossHit = (state == LINE_UP) && !dclEdge && (lossCnt == LOSS_LAST);
  assign newInd  = ciDone && prevValid && (ciCode == prevCode) && (ciCode != ciRxCode);

  assign ctl.lineUp   = (state == LINE_UP);
  assign ctl.forceLow = forceZero;
  assign ctl.dropSync = lossHit;
  assign lineActive   = (state == LINE_UP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= LINE_DOWN;
      lossCnt <= '0;
    end else begin
      if (dclEdge) lossCnt <= '0;
      else if (lossCnt != LOSS_LAST) lossCnt <= lossCnt + 1'b1;
      if (dclEdge) state <= LINE_UP;
      else if (lossHit) state <= LINE_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCode  <= '1;
      prevValid <= 1'b0;
      ciRxCode  <= '1;
      irqPend   <= 1'b0;
      irqOut    <= 1'b0;
    end else begin
      if (lossHit) begin
        prevValid <= 1'b0;
      end else if (ciDone) begin
        prevCode  <= ciCode;
        prevValid <= 1'b1;
      end
      if (newInd) ciRxCode <= ciCode;
      if (newInd) irqPend <= 1'b1;
      else if (irqClr) irqPend <= 1'b0;
      irqOut <= irqPend & irqEn;
    end
  end

  AST_IND_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (ciRxCode != $past(ciRxCode)) |-> irqPend); // R6
  AST_LOSS_DROPS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    lossHit |=> !lineActive); // R3
  AST_EDGE_RAISES_LINE: assert property (@(posedge clk) disable iff (!rstN)
    dclEdge |=> lineActive); // R2
  AST_MASK_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |=> !irqOut); // R7
endmodule

// File: rtl/gci_port.sv
module gci_port
  import gci_port_pkg::*;
#(
  parameter int FRAME_BITS  = 96,
  parameter int GRANT_POS   = 88,
  parameter int LOSS_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busClk,
  input  logic       busSync,
  input  logic       busRxd,
  output logic       txLow,
  input  logic       forceZero,
  input  logic [3:0] ciTxCode,
  input  logic       irqEn,
  input  logic       irqClr,
  output logic       lineActive,
  output logic [3:0] ciRxCode,
  output logic       irqOut,
  output logic       grantOut,
  output logic       grantStrobe
);
  ctlStrobe_t      ctl;
  logic            dclEdge;
  logic            ciDone;
  logic [CI_W-1:0] ciCode;

  gci_port_dp #(.FRAME_BITS(FRAME_BITS), .GRANT_POS(GRANT_POS)) u_dp (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busSync(busSync), .busRxd(busRxd),
    .ciTxCode(ciTxCode), .ctl(ctl), .dclEdge(dclEdge), .ciDone(ciDone),
    .ciCode(ciCode), .txLow(txLow), .grantOut(grantOut), .grantStrobe(grantStrobe)
  );

  gci_port_ctl #(.LOSS_CYCLES(LOSS_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .dclEdge(dclEdge), .ciDone(ciDone), .ciCode(ciCode),
    .forceZero(forceZero), .irqEn(irqEn), .irqClr(irqClr), .ctl(ctl),
    .lineActive(lineActive), .ciRxCode(ciRxCode), .irqOut(irqOut)
  );
endmodule

// File: tb/gci_port_bench.sv
`timescale 1ns/1ps
module gci_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busClk = 1'b0;
  logic       busSync = 1'b0;
  logic       busRxd = 1'b1;
  logic       forceZero = 1'b0;
  logic [3:0] ciTxCode = 4'hF;
  logic       irqEn = 1'b1;
  logic       irqClr = 1'b0;
  logic       txLow;
  logic       lineActive;
  logic [3:0] ciRxCode;
  logic       irqOut;
  logic       grantOut;
  logic       grantStrobe;

  int nChecks = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  gci_port u_gci_port (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busSync(busSync), .busRxd(busRxd),
    .txLow(txLow), .forceZero(forceZero), .ciTxCode(ciTxCode), .irqEn(irqEn),
    .irqClr(irqClr), .lineActive(lineActive), .ciRxCode(ciRxCode), .irqOut(irqOut),
    .grantOut(grantOut), .grantStrobe(grantStrobe)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic dclCycle(input logic fsc, input logic rxd, output logic seen);
    @(negedge clk);
    busClk = 1'b1; busSync = fsc; busRxd = rxd;
    @(negedge clk);
    @(negedge clk);
    seen = txLow;
    busClk = 1'b0; busSync = 1'b0;
    @(negedge clk);
  endtask

  // One 96-bit frame; returns the number of transmit bits differing from expectation.
  task automatic sendFrame(input logic [3:0] code, input logic grant, input logic withSync,
                           output int txErr);
    logic s, d, rxd, expLow;
    txErr = 0;
    for (int p = 0; p < 96; p++) begin
      rxd = 1'b1;
      if (p >= 26 && p <= 29) rxd = code[29-p];
      if (p == 88) rxd = grant;
      dclCycle(withSync && p == 0, rxd, s);
      dclCycle(1'b0, rxd, d);
      expLow = forceZero ? 1'b1 : ((p >= 26 && p <= 29) ? ~ciTxCode[29-p] : 1'b0);
      if (s !== expLow) txErr++;
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    check(lineActive == 1'b0, "R1 lineActive", lineActive, 0);
    check(txLow == 1'b0, "R1 txLow", txLow, 0);
    check(irqOut == 1'b0, "R1 irqOut", irqOut, 0);
    check(ciRxCode == 4'hF, "R1 ciRxCode", ciRxCode, 15);
  endtask

  task automatic testForceWhileDown();
    @(negedge clk); forceZero = 1'b1;
    repeat (3) @(negedge clk);
    check(txLow == 1'b1, "R4 force while down", txLow, 1);
    forceZero = 1'b0;
    repeat (3) @(negedge clk);
    check(txLow == 1'b0, "R4 release while down", txLow, 0);
  endtask

  task automatic testActivate();
    logic s;
    for (int i = 0; i < 4; i++) dclCycle(1'b0, 1'b1, s);
    check(lineActive == 1'b1, "R2 line up on clock", lineActive, 1);
    check(txLow == 1'b0, "R5 unframed released", txLow, 0);
  endtask

  task automatic testIndication();
    int e;
    sendFrame(4'h7, 1'b1, 1'b1, e);
    check(ciRxCode == 4'hF, "R6 single frame no latch", ciRxCode, 15);
    sendFrame(4'h7, 1'b1, 1'b1, e);
    check(ciRxCode == 4'h7, "R6 two frames latch", ciRxCode, 7);
    check(irqOut == 1'b1, "R7 irq raised", irqOut, 1);
    pulseClr();
    check(irqOut == 1'b0, "R7 irq cleared", irqOut, 0);
  endtask

  task automatic testMasked();
    int e;
    irqEn = 1'b0;
    sendFrame(4'hC, 1'b1, 1'b1, e);
    sendFrame(4'hC, 1'b1, 1'b1, e);
    check(ciRxCode == 4'hC, "R6 latch C", ciRxCode, 12);
    check(irqOut == 1'b0, "R7 masked", irqOut, 0);
    @(negedge clk); irqEn = 1'b1;
    repeat (3) @(negedge clk);
    check(irqOut == 1'b1, "R7 pending kept while masked", irqOut, 1);
    pulseClr();
  endtask

  task automatic testNoChange();
    int e;
    sendFrame(4'hC, 1'b1, 1'b1, e);
    sendFrame(4'hC, 1'b1, 1'b1, e);
    check(irqOut == 1'b0, "R6 repeat of held code", irqOut, 0);
    sendFrame(4'hA, 1'b1, 1'b1, e);
    sendFrame(4'h5, 1'b1, 1'b1, e);
    sendFrame(4'hA, 1'b1, 1'b1, e);
    check(ciRxCode == 4'hC, "R6 alternating ignored", ciRxCode, 12);
    check(irqOut == 1'b0, "R6 alternating no irq", irqOut, 0);
  endtask

  task automatic testWrap();
    int e;
    sendFrame(4'h3, 1'b1, 1'b1, e);
    sendFrame(4'h3, 1'b1, 1'b0, e);
    check(ciRxCode == 4'h3, "R9 frame without sync", ciRxCode, 3);
    pulseClr();
  endtask

  task automatic testTx();
    int e;
    ciTxCode = 4'b1010;
    sendFrame(4'h3, 1'b1, 1'b1, e);
    check(e == 0, "R5 C/I transmit bits", e, 0);
    ciTxCode = 4'b0110;
    sendFrame(4'h3, 1'b1, 1'b0, e);
    check(e == 0, "R5 C/I transmit after wrap", e, 0);
    ciTxCode = 4'hF;
  endtask

  task automatic testForceActive();
    int e;
    ciTxCode = 4'b1001;
    forceZero = 1'b1;
    sendFrame(4'h3, 1'b1, 1'b1, e);
    check(e == 0, "R4 all bits low while line up", e, 0);
    forceZero = 1'b0;
    ciTxCode = 4'hF;
  endtask

  task automatic testGrant();
    int e;
    sendFrame(4'h3, 1'b0, 1'b1, e);
    check(grantOut == 1'b0, "R8 grant 0", grantOut, 0);
    sendFrame(4'h3, 1'b1, 1'b1, e);
    check(grantOut == 1'b1, "R8 grant 1", grantOut, 1);
  endtask

  task automatic testLoss();
    repeat (40) @(negedge clk);
    check(lineActive == 1'b1, "R3 short gap keeps line", lineActive, 1);
    repeat (60) @(negedge clk);
    check(lineActive == 1'b0, "R3 loss of clock", lineActive, 0);
    check(txLow == 1'b0, "R3 output released", txLow, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForceWhileDown();
    testActivate();
    testIndication();
    testMasked();
    testNoChange();
    testWrap();
    testTx();
    testForceActive();
    testGrant();
    testLoss();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule